// File: doc/BRIEF.md
# Set-first mask generator

This block turns a source bit vector into a destination mask according to where the lowest active set bit of the source lies. A predicate vector marks which element positions take part. Positions with a predicate bit of 0 are left out of the search. They are also left out of the write: such a position reproduces the bit from an "old destination" input. The search runs from bit 0 upward.

Three result shapes are offered:
- **before** – ones strictly below the first hit.
- **through** – ones up to and including the first hit.
- **single** – a one only at the first hit.

A fourth mode code is reserved and passes the old destination through unchanged. A flag reports when no active source bit is set.

One request is accepted per cycle when `in_valid` is high. With the default parameters the result and flag are registered and appear one cycle later, qualified by `out_valid`. The carry-style prefix OR that locates the first hit can be built as a ripple chain or as a logarithmic tree.

Top module: `sfm_mask_gen`

## Requirements
- R1: Mode 2'b00 (before): every active position below the lowest active set source bit reads 1. That position and every active position above it read 0. A source with bit 0 set and active gives 0 on all active positions.
- R2: Mode 2'b00 with no active source bit set gives 1 on every active position.
- R3: Mode 2'b01 (through): every active position up to and including the lowest active set source bit reads 1, and all active positions above it read 0. With no active hit, every active position reads 1.
- R4: Mode 2'b10 (single): only the lowest active set source bit position reads 1, and every other active position reads 0.
- R5: A position whose predicate bit is 0 outputs the old-destination bit of that position, in every mode.
- R6: Source bits at positions whose predicate bit is 0 have no effect on the search, on the result or on the none flag.
- R7: Mode 2'b11 is reserved and outputs the old destination unchanged on all positions.
- R8: `out_none` is 1 exactly when no position has both its source bit and its predicate bit set.
- R9: With REG_OUT=1, `out_valid` rises in the cycle after each accepted request and is 0 otherwise. `out_mask` and `out_none` hold their last values while no request is accepted.
- R10: While `rst_n` is low, `out_valid`, `out_mask` and `out_none` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request strobe |
| in_mode | input | 2 | 00 before, 01 through, 10 single, 11 reserved |
| in_src | input | WIDTH | Source vector searched from bit 0 upward |
| in_pred | input | WIDTH | Predicate; 1 marks an active position |
| in_old | input | WIDTH | Old destination copied to inactive positions |
| out_valid | output | 1 | Result strobe |
| out_mask | output | WIDTH | Resulting mask |
| out_none | output | 1 | No active source bit was set |

## Verification
A broken prefix OR (a missing span in the tree, or an off-by-one shift of the exclusive prefix) shows at the ports as a transition edge in `out_mask` that sits one or more places away from the lowest active hit. It appears one cycle after the offending request, so every request is scored against its own result. Leaking the predicate into the search or the write shows as a changed flag or a changed old-destination bit at an inactive position. Stimulus therefore places set source bits at inactive positions and below the first active hit, and it uses hits at bit 0 and bit 63.

// File: rtl/sfm_pkg.sv
package sfm_pkg;

   typedef enum logic [1:0] {
      SFM_BEFORE  = 2'b00,
      SFM_THROUGH = 2'b01,
      SFM_SINGLE  = 2'b10,
      SFM_RSVD    = 2'b11
   } sfm_mode_e;

   localparam int SFM_STYLE_RIPPLE = 0;
   localparam int SFM_STYLE_TREE   = 1;

endpackage

// File: rtl/sfm_prefix_or.sv
// Inclusive prefix OR: any_incl[i] = |hit[i:0].
module sfm_prefix_or #(
   parameter int W     = 64,
   parameter int STYLE = sfm_pkg::SFM_STYLE_TREE
) (
   input  logic [W-1:0] hit,
   output logic [W-1:0] any_incl
);

   localparam int STAGES = (W > 1) ? $clog2(W) : 1;

   if (W < 2) begin : g_bad_width
      $error("sfm_prefix_or: W must be at least 2");
   end

   if (STYLE == sfm_pkg::SFM_STYLE_RIPPLE) begin : g_ripple
      always_comb begin
         logic acc;
         acc = 1'b0;
         for (int i = 0; i < W; i++) begin
            acc         = acc | hit[i];
            any_incl[i] = acc;
         end
      end
   end else if (STYLE == sfm_pkg::SFM_STYLE_TREE) begin : g_tree
      for (genvar s = 0; s < STAGES; s++) begin : g_stg
         localparam int SPAN = 1 << s;
         logic [W-1:0] prv;
         logic [W-1:0] nxt;
         if (s == 0) begin : g_first
            assign prv = hit;
         end else begin : g_chain
            assign prv = g_stg[s-1].nxt;
         end
         always_comb begin
            nxt = prv;
            for (int i = SPAN; i < W; i++) begin
               nxt[i] = prv[i] | prv[i-SPAN];
            end
         end
      end
      assign any_incl = g_stg[STAGES-1].nxt;
   end else begin : g_bad_style
      $error("sfm_prefix_or: STYLE must be 0 or 1");
      assign any_incl = '0;
   end

endmodule

// File: rtl/sfm_mode_apply.sv
// Shapes the mask from the prefix and merges it with the old destination.
module sfm_mode_apply #(
   parameter int W = 64
) (
   input  sfm_pkg::sfm_mode_e mode,
   input  logic [W-1:0]       hit,
   input  logic [W-1:0]       any_incl,
   input  logic [W-1:0]       pred,
   input  logic [W-1:0]       old,
   output logic [W-1:0]       mask,
   output logic               none
);

   logic [W-1:0] any_excl;
   logic [W-1:0] shape_before;
   logic [W-1:0] shape_through;
   logic [W-1:0] shape_single;
   logic [W-1:0] active_val;

   assign any_excl      = {any_incl[W-2:0], 1'b0};
   assign shape_before  = ~any_incl;
   assign shape_through = ~any_excl;
   assign shape_single  = hit & ~any_excl;
   assign none          = ~any_incl[W-1];

   always_comb begin
      unique case (mode)
         sfm_pkg::SFM_BEFORE:  active_val = shape_before;
         sfm_pkg::SFM_THROUGH: active_val = shape_through;
         sfm_pkg::SFM_SINGLE:  active_val = shape_single;
         default:              active_val = old;
      endcase
   end

   assign mask = (active_val & pred) | (old & ~pred);

endmodule

// File: rtl/sfm_mask_gen.sv
module sfm_mask_gen #(
   parameter int WIDTH        = 64,
   parameter int PREFIX_STYLE = sfm_pkg::SFM_STYLE_TREE,
   parameter int REG_OUT      = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic [1:0]       in_mode,
   input  logic [WIDTH-1:0] in_src,
   input  logic [WIDTH-1:0] in_pred,
   input  logic [WIDTH-1:0] in_old,
   output logic             out_valid,
   output logic [WIDTH-1:0] out_mask,
   output logic             out_none
);

   if (WIDTH < 2) begin : g_chk_width
      $error("sfm_mask_gen: WIDTH must be at least 2");
   end
   if (REG_OUT != 0 && REG_OUT != 1) begin : g_chk_reg
      $error("sfm_mask_gen: REG_OUT must be 0 or 1");
   end

   logic [WIDTH-1:0] hit;
   logic [WIDTH-1:0] any_incl;
   logic [WIDTH-1:0] nxt_mask;
   logic             nxt_none;

   assign hit = in_src & in_pred;

   sfm_prefix_or #(
      .W     (WIDTH),
      .STYLE (PREFIX_STYLE)
   ) u_prefix (
      .hit      (hit),
      .any_incl (any_incl)
   );

   sfm_mode_apply #(
      .W (WIDTH)
   ) u_apply (
      .mode     (sfm_pkg::sfm_mode_e'(in_mode)),
      .hit      (hit),
      .any_incl (any_incl),
      .pred     (in_pred),
      .old      (in_old),
      .mask     (nxt_mask),
      .none     (nxt_none)
   );

   if (REG_OUT == 1) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            out_valid <= 1'b0;
            out_mask  <= '0;
            out_none  <= 1'b0;
         end else begin
            out_valid <= in_valid;
            if (in_valid) begin
               out_mask <= nxt_mask;
               out_none <= nxt_none;
            end
         end
      end
   end else begin : g_comb
      assign out_valid = in_valid;
      assign out_mask  = nxt_mask;
      assign out_none  = nxt_none;
   end

endmodule

module sfm_mask_gen_chk #(
   parameter int W       = 64,
   parameter int REG_OUT = 1
) (
   input logic         clk,
   input logic         rst_n,
   input logic         in_valid,
   input logic [1:0]   in_mode,
   input logic [W-1:0] in_src,
   input logic [W-1:0] in_pred,
   input logic [W-1:0] in_old,
   input logic         out_valid,
   input logic [W-1:0] out_mask,
   input logic         out_none
);

   if (REG_OUT == 1) begin : g_seq
      a_r9_valid_follows : assert property (@(posedge clk) disable iff (!rst_n)
         in_valid |=> out_valid);
      a_r9_valid_idle : assert property (@(posedge clk) disable iff (!rst_n)
         !in_valid |=> !out_valid);
      a_r9_hold : assert property (@(posedge clk) disable iff (!rst_n)
         !in_valid |=> ($stable(out_mask) && $stable(out_none)));
      a_r5_inactive_keep : assert property (@(posedge clk) disable iff (!rst_n)
         in_valid |=> (((out_mask ^ $past(in_old)) & ~$past(in_pred)) == '0));
      a_r8_none_flag : assert property (@(posedge clk) disable iff (!rst_n)
         in_valid |=> (out_none == (($past(in_src) & $past(in_pred)) == '0)));
      a_r7_reserved : assert property (@(posedge clk) disable iff (!rst_n)
         (in_valid && in_mode == 2'b11) |=> (out_mask == $past(in_old)));
      a_r4_single_onehot : assert property (@(posedge clk) disable iff (!rst_n)
         (in_valid && in_mode == 2'b10) |=> $onehot0(out_mask & $past(in_pred)));
      a_r2_empty_all_ones : assert property (@(posedge clk) disable iff (!rst_n)
         (in_valid && in_mode == 2'b00 && (in_src & in_pred) == '0)
            |=> ((out_mask & $past(in_pred)) == $past(in_pred)));
   end

   always @(posedge clk) begin
      if (!rst_n) begin
         a_r10_reset_state : assert (REG_OUT == 0 || (!out_valid && out_mask == '0 && !out_none));
      end
   end

endmodule

bind sfm_mask_gen sfm_mask_gen_chk #(
   .W       (WIDTH),
   .REG_OUT (REG_OUT)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .in_mode   (in_mode),
   .in_src    (in_src),
   .in_pred   (in_pred),
   .in_old    (in_old),
   .out_valid (out_valid),
   .out_mask  (out_mask),
   .out_none  (out_none)
);

// File: tb/sfm_mask_gen_tb.sv
`timescale 1ns/1ps
module sfm_mask_gen_tb;

   localparam int W = 64;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         in_valid = 1'b0;
   logic [1:0]   in_mode = 2'b00;
   logic [W-1:0] in_src = '0;
   logic [W-1:0] in_pred = '0;
   logic [W-1:0] in_old = '0;
   logic         out_valid;
   logic [W-1:0] out_mask;
   logic         out_none;

   always #2 clk = ~clk;

   sfm_mask_gen #(.WIDTH(W)) u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (in_valid),
      .in_mode   (in_mode),
      .in_src    (in_src),
      .in_pred   (in_pred),
      .in_old    (in_old),
      .out_valid (out_valid),
      .out_mask  (out_mask),
      .out_none  (out_none)
   );

   typedef struct {
      logic [W-1:0] mask;
      logic         none;
      string        tag;
   } exp_t;

   exp_t         sb[$];
   int           checks = 0;
   int           fails  = 0;
   logic [W-1:0] last_mask = '0;
   logic         last_none = 1'b0;

   // Reference: sequential scan from bit 0 upward.
   function automatic exp_t model(logic [1:0] m, logic [W-1:0] s, logic [W-1:0] p,
                                  logic [W-1:0] o, string tag);
      exp_t e;
      bit   found = 0;
      bit   first;
      e.tag = tag;
      for (int i = 0; i < W; i++) begin
         if (!p[i] || m == 2'b11) begin
            e.mask[i] = o[i];
         end else begin
            first = s[i] && !found;
            case (m)
               2'b00:   e.mask[i] = !found && !first;
               2'b01:   e.mask[i] = !found;
               default: e.mask[i] = first;
            endcase
            if (s[i]) found = 1;
         end
      end
      e.none = ((s & p) == '0);
      return e;
   endfunction

   task automatic check(bit ok, string tag, logic [W-1:0] act, logic [W-1:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic send(logic [1:0] m, logic [W-1:0] s, logic [W-1:0] p,
                       logic [W-1:0] o, string tag);
      @(negedge clk);
      in_valid = 1'b1;
      in_mode  = m;
      in_src   = s;
      in_pred  = p;
      in_old   = o;
      sb.push_back(model(m, s, p, o, tag));
   endtask

   task automatic idle(int n);
      for (int k = 0; k < n; k++) begin
         @(negedge clk);
         in_valid = 1'b0;
         in_src   = ~in_src;
         in_old   = ~in_old;
      end
   endtask

   // Monitor: pops one expected item per result.
   always @(negedge clk) begin
      if (rst_n && out_valid) begin
         if (sb.size() == 0) begin
            check(1'b0, "R9 unexpected out_valid", {{(W-1){1'b0}}, out_valid}, '0);
         end else begin
            exp_t e;
            e = sb.pop_front();
            check(out_mask == e.mask, {e.tag, " mask"}, out_mask, e.mask);
            check(out_none == e.none, "R8 none flag", {{(W-1){1'b0}}, out_none},
                  {{(W-1){1'b0}}, e.none});
            last_mask = e.mask;
            last_none = e.none;
         end
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   localparam logic [W-1:0] ALL  = '1;
   localparam logic [W-1:0] OLDP = 64'hA5A5_3C3C_0F0F_9696;

   initial begin
      logic [W-1:0] rs;
      logic [W-1:0] rp;
      logic [1:0]   rm;
      // R10: reset state
      in_src = ALL;
      in_old = ALL;
      repeat (3) @(negedge clk);
      check(!out_valid && out_mask == '0 && !out_none, "R10 reset outputs",
            out_mask, '0);
      rst_n = 1'b1;
      @(negedge clk);
      check(!out_valid, "R10 idle after reset", {{(W-1){1'b0}}, out_valid}, '0);

      send(2'b00, 64'h94, ALL, OLDP, "R1 before-first");
      send(2'b00, 64'h95, ALL, OLDP, "R1 bit0 hit");
      send(2'b00, 64'h0,  ALL, OLDP, "R2 empty source");
      send(2'b01, 64'h94, ALL, OLDP, "R3 through");
      send(2'b01, 64'h95, ALL, OLDP, "R3 bit0 hit");
      send(2'b01, 64'h8000_0000_0000_0000, ALL, OLDP, "R3 top-bit hit");
      send(2'b10, 64'h94, ALL, OLDP, "R4 single");
      send(2'b10, 64'h0,  ALL, OLDP, "R4 single empty");
      send(2'b00, 64'h94, 64'hC3, OLDP, "R5 predicated before");
      send(2'b10, 64'hD4, 64'hC3, OLDP, "R6 predicated single");
      send(2'b00, 64'h3C, 64'hC3, OLDP, "R6 hits only inactive");
      send(2'b11, 64'h94, ALL, OLDP, "R7 reserved");
      send(2'b11, 64'h94, 64'hC3, ~OLDP, "R7 reserved predicated");
      idle(4);
      // R9: outputs hold while idle
      check(!out_valid && out_mask == last_mask && out_none == last_none,
            "R9 hold while idle", out_mask, last_mask);

      for (int n = 0; n < 60; n++) begin
         rs = {$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom};
         rp = {$urandom, $urandom} | {$urandom, $urandom};
         rm = 2'($urandom % 4);
         send(rm, rs, rp, {$urandom, $urandom}, "R5 random mixed");
         if (n % 7 == 3) idle(1);
      end
      idle(3);
      check(sb.size() == 0, "R9 scoreboard drained", W'(sb.size()), '0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule